// File: doc/BRIEF.md
# Boundary-Scan Register Chain with Per-Pad Enable Cells

This block is the data register that sits between a test access port and a row of bidirectional pads. Each pad owns two chain cells: an enable cell that decides whether the pad driver is on, and a data cell that holds the value to drive and records what the pad sees. A short run of fixed internal cells sits at the serial-output end. The test access port state machine supplies the capture, shift and update strobes and the two mode levels. The block itself holds no state machine.

In functional mode the core's data and enable reach the pads unchanged. In external-test mode the update latches drive the pads. In high-impedance mode every driver is switched off. Serial shifting never disturbs the pads, because only the update strobe copies the shift stages into the latches. A sample/preload pass can therefore run while the chip operates. After reset all latches hold safe values, so entering external-test mode before any preload leaves every pad floating.

Top module: `bscan_chain`

## Requirements
- R1: After reset, and before the first update strobe, external-test mode with high-impedance mode off drives every pad enable low and every pad data output low.
- R2: With external-test mode off, pad_do equals core_do. With high-impedance mode also off, pad_oe equals core_oe. core_di always equals pad_di.
- R3: A capture strobe loads each data cell with its pad_di bit and each enable cell with the inverse of its core_oe bit, so that 1 means disabled. Each internal cell reloads its fixed value. Capture takes priority over shift in the same cycle.
- R4: Cell k of the chain, counted from the tdo end, is: internal cell k for k below NUM_INT, the data cell of pad p at NUM_INT+2p, and the enable cell of pad p at NUM_INT+2p+1. Each shift strobe moves every cell one place toward tdo and loads tdi into the last cell. tdo shows cell 0, so the bit shifted in first leaves first, after exactly 2*NUM_PADS+NUM_INT shifts.
- R5: The update latches change only on the update strobe. Shifting or capturing in external-test mode leaves pad_do and pad_oe unchanged.
- R6: In external-test mode pad_do is the data cell's latch and pad_oe is the inverse of the enable cell's latch.
- R7: While high-impedance mode is on, every pad_oe bit is 0, whatever the latches or core_oe hold.
- R8: Reset loads every shift stage with its safe value: 1 in enable cells and 0 in data cells. The internal cells take INT_SAFE, whose bit k belongs to internal cell k (default 5'b10111, so cell 3 is 0 and the rest are 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial input at the far end of the chain |
| tdo | output | 1 | Serial output, value of cell 0 |
| capture_dr | input | 1 | Capture strobe, one cycle |
| shift_dr | input | 1 | Shift strobe, one cycle per bit |
| update_dr | input | 1 | Update strobe, copies stages into latches |
| extest | input | 1 | External-test mode level |
| highz | input | 1 | High-impedance mode level |
| core_do | input | NUM_PADS | Core data toward pads |
| core_oe | input | NUM_PADS | Core output enables, 1 drives |
| core_di | output | NUM_PADS | Pad input values returned to core |
| pad_do | output | NUM_PADS | Data to pad drivers |
| pad_oe | output | NUM_PADS | Pad driver enables, 1 drives |
| pad_di | input | NUM_PADS | Values seen at pads |

## Verification
The hardest case to reach is external-test mode running while a fresh vector shifts through the chain. The pads must keep the previously latched values, even though every stage behind them changes. The stimulus first preloads and updates one vector and enters external-test mode. It then shifts a second vector through, checks the pads before the next update strobe, and checks that the first vector emerges at tdo after exactly one chain length. The other hard case is external-test mode entered straight after reset, which the bench reaches before any update strobe and again after a mid-run reset.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
   typedef enum logic [1:0] {
      CELL_DATA = 2'd0,
      CELL_CTRL = 2'd1
   } cell_kind_e;

   localparam logic CTRL_SAFE = 1'b1;
   localparam logic DATA_SAFE = 1'b0;
endpackage

// File: rtl/bsr_io_cell.sv
module bsr_io_cell
   import bsr_pkg::*;
#(
   parameter cell_kind_e KIND = CELL_DATA
) (
   input  logic tck,
   input  logic rst_n,
   input  logic cap,
   input  logic shf,
   input  logic upd,
   input  logic cap_val,
   input  logic ser_in,
   output logic stage_q,
   output logic latch_q
);
   localparam logic SAFE = (KIND == CELL_CTRL) ? CTRL_SAFE : DATA_SAFE;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      stage_q <= SAFE;
      else if (cap)    stage_q <= cap_val;
      else if (shf)    stage_q <= ser_in;
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      latch_q <= SAFE;
      else if (upd)    latch_q <= stage_q;
   end
endmodule

// File: rtl/bsr_int_cell.sv
module bsr_int_cell #(
   parameter logic SAFE = 1'b1
) (
   input  logic tck,
   input  logic rst_n,
   input  logic cap,
   input  logic shf,
   input  logic ser_in,
   output logic stage_q
);
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      stage_q <= SAFE;
      else if (cap)    stage_q <= SAFE;
      else if (shf)    stage_q <= ser_in;
   end
endmodule

// File: rtl/bsr_pad_mux.sv
module bsr_pad_mux (
   input  logic core_do,
   input  logic core_oe,
   input  logic lat_do,
   input  logic lat_dis,
   input  logic extest,
   input  logic highz,
   output logic pad_do,
   output logic pad_oe
);
   always_comb begin
      pad_do = extest ? lat_do : core_do;
      if (highz)       pad_oe = 1'b0;
      else if (extest) pad_oe = ~lat_dis;
      else             pad_oe = core_oe;
   end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
   import bsr_pkg::*;
#(
   parameter int NUM_PADS = 104,
   parameter int NUM_INT  = 5,
   parameter logic [NUM_INT-1:0] INT_SAFE = 5'b10111
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic                tdi,
   output logic                tdo,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic                extest,
   input  logic                highz,
   input  logic [NUM_PADS-1:0] core_do,
   input  logic [NUM_PADS-1:0] core_oe,
   output logic [NUM_PADS-1:0] core_di,
   output logic [NUM_PADS-1:0] pad_do,
   output logic [NUM_PADS-1:0] pad_oe,
   input  logic [NUM_PADS-1:0] pad_di
);
   localparam int CHAIN_LEN = 2 * NUM_PADS + NUM_INT;
   localparam int PAD_BASE  = NUM_INT;

   if (NUM_PADS < 1) begin : g_bad_pads
      $error("bscan_chain: NUM_PADS must be at least 1");
   end
   if (NUM_INT < 1) begin : g_bad_int
      $error("bscan_chain: NUM_INT must be at least 1");
   end

   logic [CHAIN_LEN-1:0] stage_q;
   logic [CHAIN_LEN-1:0] ser_in;

   // each stage takes its neighbour on the tdi side; the last one takes tdi
   assign ser_in = {tdi, stage_q[CHAIN_LEN-1:1]};
   assign tdo    = stage_q[0];
   assign core_di = pad_di;

   for (genvar i = 0; i < NUM_INT; i++) begin : g_int
      bsr_int_cell #(.SAFE(INT_SAFE[i])) u_cell (
         .tck     (tck),
         .rst_n   (trst_n),
         .cap     (capture_dr),
         .shf     (shift_dr),
         .ser_in  (ser_in[i]),
         .stage_q (stage_q[i])
      );
   end

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      localparam int DI = PAD_BASE + 2 * p;
      localparam int CI = PAD_BASE + 2 * p + 1;
      logic lat_do;
      logic lat_dis;

      bsr_io_cell #(.KIND(CELL_DATA)) u_data (
         .tck     (tck),
         .rst_n   (trst_n),
         .cap     (capture_dr),
         .shf     (shift_dr),
         .upd     (update_dr),
         .cap_val (pad_di[p]),
         .ser_in  (ser_in[DI]),
         .stage_q (stage_q[DI]),
         .latch_q (lat_do)
      );

      bsr_io_cell #(.KIND(CELL_CTRL)) u_ctrl (
         .tck     (tck),
         .rst_n   (trst_n),
         .cap     (capture_dr),
         .shf     (shift_dr),
         .upd     (update_dr),
         .cap_val (~core_oe[p]),
         .ser_in  (ser_in[CI]),
         .stage_q (stage_q[CI]),
         .latch_q (lat_dis)
      );

      bsr_pad_mux u_mux (
         .core_do (core_do[p]),
         .core_oe (core_oe[p]),
         .lat_do  (lat_do),
         .lat_dis (lat_dis),
         .extest  (extest),
         .highz   (highz),
         .pad_do  (pad_do[p]),
         .pad_oe  (pad_oe[p])
      );
   end
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
   parameter int NUM_PADS = 104
) (
   input logic                tck,
   input logic                trst_n,
   input logic                update_dr,
   input logic                extest,
   input logic                highz,
   input logic [NUM_PADS-1:0] core_do,
   input logic [NUM_PADS-1:0] core_oe,
   input logic [NUM_PADS-1:0] core_di,
   input logic [NUM_PADS-1:0] pad_do,
   input logic [NUM_PADS-1:0] pad_oe,
   input logic [NUM_PADS-1:0] pad_di
);
   logic seen_upd;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)        seen_upd <= 1'b0;
      else if (update_dr) seen_upd <= 1'b1;
   end

   assert_safe_float_R1: assert property (@(posedge tck) disable iff (!trst_n)
      (extest && !highz && !seen_upd) |-> (pad_oe == '0 && pad_do == '0));

   assert_func_data_R2: assert property (@(posedge tck) disable iff (!trst_n)
      !extest |-> pad_do == core_do);

   assert_func_oe_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (!extest && !highz) |-> pad_oe == core_oe);

   assert_loopback_R2: assert property (@(posedge tck) disable iff (!trst_n)
      core_di == pad_di);

   assert_latch_hold_R5: assert property (@(posedge tck) disable iff (!trst_n)
      (extest && !highz && !update_dr) |=>
         (!extest || highz || ($stable(pad_do) && $stable(pad_oe))));

   assert_highz_off_R7: assert property (@(posedge tck) disable iff (!trst_n)
      highz |-> pad_oe == '0);
endmodule

bind bscan_chain bscan_chain_chk #(.NUM_PADS(NUM_PADS)) u_chk (
   .tck       (tck),
   .trst_n    (trst_n),
   .update_dr (update_dr),
   .extest    (extest),
   .highz     (highz),
   .core_do   (core_do),
   .core_oe   (core_oe),
   .core_di   (core_di),
   .pad_do    (pad_do),
   .pad_oe    (pad_oe),
   .pad_di    (pad_di)
);

// File: tb/tb_bscan_chain.sv
module tb_bscan_chain;
   localparam int NP  = 4;
   localparam int NI  = 5;
   localparam int LEN = 2 * NP + NI;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic extest = 1'b0, highz = 1'b0;
   logic [NP-1:0] core_do = '0, core_oe = '0, pad_di = '0;
   logic [NP-1:0] core_di, pad_do, pad_oe;
   logic tdo;

   int checks = 0;
   int errors = 0;
   logic  exp_q[$];
   string tag_q[$];

   always #5 tck = ~tck;

   bscan_chain #(.NUM_PADS(NP), .NUM_INT(NI), .INT_SAFE(5'b10111)) dut (
      .tck(tck), .trst_n(trst_n), .tdi(tdi), .tdo(tdo),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
      .extest(extest), .highz(highz),
      .core_do(core_do), .core_oe(core_oe), .core_di(core_di),
      .pad_do(pad_do), .pad_oe(pad_oe), .pad_di(pad_di)
   );

   // chain image by cell index: internal safe bits, then data/disable per pad
   function automatic logic [LEN-1:0] build(input logic [NP-1:0] d,
                                            input logic [NP-1:0] dis);
      logic [LEN-1:0] v;
      v[NI-1:0] = 5'b10111;
      for (int p = 0; p < NP; p++) begin
         v[NI + 2*p]     = d[p];
         v[NI + 2*p + 1] = dis[p];
      end
      return v;
   endfunction

   task automatic check(input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: compares tdo against the scoreboard during each shift cycle
   always @(negedge tck) begin
      if (shift_dr && exp_q.size() > 0) begin
         logic  e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, {31'd0, tdo}, {31'd0, e});
      end
   end

   task automatic shift_vec(input logic [LEN-1:0] v, input bit expect_on,
                            input logic [LEN-1:0] exp, input string req);
      if (expect_on)
         for (int k = 0; k < LEN; k++) begin
            exp_q.push_back(exp[k]);
            tag_q.push_back(req);
         end
      for (int k = 0; k < LEN; k++) begin
         tdi = v[k];
         shift_dr = 1'b1;
         @(posedge tck); #1;
      end
      shift_dr = 1'b0;
      tdi = 1'b0;
   endtask

   task automatic pulse_capture();
      capture_dr = 1'b1; @(posedge tck); #1; capture_dr = 1'b0;
   endtask

   task automatic pulse_update();
      update_dr = 1'b1; @(posedge tck); #1; update_dr = 1'b0;
   endtask

   task automatic do_reset();
      trst_n = 1'b0;
      repeat (3) @(posedge tck);
      #1 trst_n = 1'b1;
      @(posedge tck); #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [LEN-1:0] pre_a, pre_b, pat;
      core_do = 4'b0101; core_oe = 4'b0011; pad_di = 4'b1100;
      do_reset();

      // R2 functional pass-through
      #2;
      check("R2 pad_do", pad_do, 4'b0101);
      check("R2 pad_oe", pad_oe, 4'b0011);
      check("R2 core_di", core_di, 4'b1100);

      // R1 external test straight after reset floats every pad
      extest = 1'b1; #2;
      check("R1 pad_oe", pad_oe, 4'b0000);
      check("R1 pad_do", pad_do, 4'b0000);
      extest = 1'b0;
      @(posedge tck); #1;

      // R8 reset contents of the shift stages
      shift_vec('0, 1'b1, build(4'b0000, 4'b1111), "R8 reset stages");

      // R3 capture of pad inputs and inverted core enables
      pad_di = 4'b1010; core_oe = 4'b0110;
      pulse_capture();
      shift_vec('0, 1'b1, build(4'b1010, ~4'b0110), "R3 capture");

      // R3 capture wins over shift in the same cycle
      pad_di = 4'b0011; core_oe = 4'b1111;
      capture_dr = 1'b1; shift_dr = 1'b1; tdi = 1'b0;
      @(posedge tck); #1;
      capture_dr = 1'b0; shift_dr = 1'b0;
      shift_vec('0, 1'b1, build(4'b0011, 4'b0000), "R3 capture priority");

      // R6 preload then external test
      pre_a = build(4'b0110, 4'b1010);
      shift_vec(pre_a, 1'b0, '0, "");
      pulse_update();
      extest = 1'b1; #2;
      check("R6 pad_do", pad_do, 4'b0110);
      check("R6 pad_oe", pad_oe, 4'b0101);

      // R5 and R4: shift new vector while pads hold; old vector exits after LEN
      pre_b = build(4'b1001, 4'b0000);
      shift_vec(pre_b, 1'b1, pre_a, "R4 chain length");
      check("R5 pad_do hold", pad_do, 4'b0110);
      check("R5 pad_oe hold", pad_oe, 4'b0101);
      pulse_capture();
      check("R5 capture no effect", pad_do, 4'b0110);
      shift_vec(pre_b, 1'b0, '0, "");
      pulse_update();
      #2;
      check("R6 pad_do second", pad_do, 4'b1001);
      check("R6 pad_oe second", pad_oe, 4'b1111);

      // R7 high impedance overrides latches and core
      highz = 1'b1; #2;
      check("R7 extest pad_oe", pad_oe, 4'b0000);
      check("R7 extest pad_do", pad_do, 4'b1001);
      extest = 1'b0; core_oe = 4'b1111; core_do = 4'b1110; #2;
      check("R7 func pad_oe", pad_oe, 4'b0000);
      check("R2 func pad_do under highz", pad_do, 4'b1110);
      highz = 1'b0; #2;
      check("R2 func pad_oe", pad_oe, 4'b1111);

      // R4 arbitrary pattern round trip
      pat = 13'b1011001110010;
      shift_vec(pat, 1'b0, '0, "");
      shift_vec('0, 1'b1, pat, "R4 round trip");

      // R1 after a mid-run reset
      do_reset();
      extest = 1'b1; #2;
      check("R1 after re-reset pad_oe", pad_oe, 4'b0000);
      extest = 1'b0;
      @(posedge tck); #1;
      check("R4 scoreboard empty", exp_q.size(), 0);

      finish_run();
   end
endmodule